// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps wall-clock time and a calendar date in packed BCD. A one-cycle tick enable at the crystal rate (32768 per second by default) advances a sub-second divider. Each divider wrap steps a cascade of BCD counters: seconds, minutes, 24-hour hours, day of month, month, two-digit year (2000 to 2099) and a 0 to 6 weekday. Software reaches the core through a flat byte-wide register port. Writes take effect at the clock edge. Reads are combinational from the address.

Software stops the clock and loads the date and time, then restarts it. To read the time, it pulses a snapshot bit, which copies every live counter into a shadow bank in one clock. Time reads always return that shadow bank, so a read never shows a half-updated carry. A signed drift correction can be applied once per hour to the sub-second divider. A six-field alarm comparator raises a sticky flag, and a maskable interrupt follows that flag.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the live and shadow time read as 00:00:00, day 01, month 01, year 00, weekday 0. Control, alarm-enable and compensation registers read 0. The alarm flag is clear and `alarm_irq` is low.
- R2: The register map is as follows. Time fields sit at addresses 0x00 to 0x06 in this order: seconds, minutes, hours, day, month, year, weekday. Alarm fields sit at 0x08 to 0x0D in the same order without weekday. Control is at 0x10, with bit0 = run, bit1 = snapshot and bit2 = compensation enable. Status is at 0x11, with bit0 = running and bit1 = alarm flag. Alarm interrupt enable is bit0 of 0x12. The compensation value is split across 0x13 (low byte) and 0x14 (high byte). Unmapped addresses read 0.
- R3: While run is 1, the seconds field advances once every 2^SUB_W accepted ticks. No counting happens while run is 0.
- R4: Status bit0 follows the run bit one clock later. Writes to time addresses load the live counters only while run is 0 and are ignored while it is 1. Clearing run restarts the sub-second phase, so after restart the first step needs a full 2^SUB_W ticks.
- R5: A control write that moves the snapshot bit from 0 to 1 copies all seven live fields into the shadow bank at that write's clock edge. The copy takes the values held before any seconds step in that same edge. A write that leaves the snapshot bit at 1 does not copy. Reads of time addresses return the shadow bank.
- R6: Seconds and minutes wrap 59 to 00 and hours wrap 23 to 00. On the hours wrap, the day advances, returning to 01 after the month's last day. February has 29 days when the year is divisible by 4 and 28 otherwise. April, June, September and November have 30 days and all other months have 31. Month wraps 12 to 01, year wraps 99 to 00, and weekday wraps 6 to 0 on every day rollover.
- R7: With compensation enabled, the value C is used on the step that takes seconds from 00 to 01 while minutes are 00. C is saturated to ±(2^SUB_W−1). The second that follows that step lasts 2^SUB_W − C ticks, so a positive C shortens it and a negative C lengthens it.
- R8: Compensation has no effect when it is disabled, when minutes are not 00, or on any step other than 00 to 01. Those seconds last 2^SUB_W ticks.
- R9: One clock after a seconds step, if the six live fields equal the six alarm fields, the alarm flag is set. It stays set until a status write with bit1 = 1. A status write with bit1 = 0 leaves it set. If a set and a clear land in the same clock, the set wins.
- R10: `alarm_irq` is high exactly when the alarm flag and the alarm interrupt enable are both 1.
- R11: The two compensation bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per crystal period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| alarm_irq | output | 1 | Alarm interrupt, flag AND enable |

## Verification
Two pairs of functions can meet in one clock, and the bench drives each pair onto the same edge on purpose. In the first pair, a snapshot request is written on the very edge where the last tick of a second makes the seconds counter step. The shadow must then hold the pre-step seconds, and a fresh snapshot must show the new value. In the second pair, a write-one-to-clear of the alarm flag is placed in the clock where a match after a step sets that flag. The flag must survive, and the interrupt must stay high. The bench controls every tick, so each of these edges is chosen by counting ticks, not by waiting on the design.

// File: rtl/rtc_pkg.sv
// Package rtc_pkg
// Shared field indices, register offsets and BCD calendar helpers for the
// clock core. Assumes every time field is one packed-BCD byte.
package rtc_pkg;

    localparam int NFIELD = 7;          // live time fields
    localparam int NALARM = 6;          // alarm fields (no weekday)

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;
    localparam int F_WDAY = 6;

    localparam int A_TIME0 = 'h00;
    localparam int A_ALM0  = 'h08;
    localparam int A_CTRL  = 'h10;
    localparam int A_STAT  = 'h11;
    localparam int A_IEN   = 'h12;
    localparam int A_CMPL  = 'h13;
    localparam int A_CMPH  = 'h14;

    localparam int C_RUN  = 0;
    localparam int C_SNAP = 1;
    localparam int C_COMP = 2;

    typedef logic [NFIELD-1:0][7:0] rtc_fields_t;
    typedef logic [NALARM-1:0][7:0] rtc_alarm_t;

    // Value held by every live field after reset.
    function automatic rtc_fields_t reset_fields();
        rtc_fields_t f;
        f         = '0;
        f[F_DAY]  = 8'h01;
        f[F_MON]  = 8'h01;
        return f;
    endfunction

    // Increment a packed-BCD byte by one (no wrap handling).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // Leap test for a two-digit BCD year inside 2000..2099.
    function automatic logic bcd_leap(input logic [7:0] yr);
        logic [5:0] s;
        s = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    // Last day of a BCD month in a given BCD year.
    function automatic logic [7:0] bcd_last_day(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_subsec.sv
// Module rtc_subsec
// Sub-second divider. Counts accepted ticks and pulses sec_step on the
// tick that completes a second. On a step flagged by comp_evt the counter
// is preloaded with the saturated signed correction instead of zero.
// Assumes comp_evt is valid in the same cycle as the completing tick.
module rtc_subsec #(
    parameter int SUB_W = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        tick_en,
    input  logic        comp_evt,
    input  logic [15:0] comp_val,
    output logic        sec_step
);
    localparam int SW   = SUB_W + 1;
    localparam int MAXV = (1 << SUB_W) - 1;

    logic signed [SW-1:0] sub_q;
    logic signed [SW-1:0] preload;
    int                   cv;

    // Clamp the 16-bit correction into the counter's usable range.
    always_comb begin
        cv = int'($signed(comp_val));
        if (cv > MAXV)       cv = MAXV;
        else if (cv < -MAXV) cv = -MAXV;
        preload = SW'(cv);
    end

    // Last tick of the current second.
    assign sec_step = run && tick_en && (sub_q == SW'(MAXV));

    // Advance, wrap or preload the divider; hold it at zero while halted.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sub_q <= '0;
        end else if (tick_en) begin
            if (sec_step) sub_q <= comp_evt ? preload : '0;
            else          sub_q <= sub_q + SW'(1);
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
// Module rtc_calendar
// Live BCD time and date counters. A per-field load strobe overwrites a
// field; otherwise sec_step ripples a carry from seconds up to year and
// weekday. Assumes loads are only issued while the divider is halted.
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_step,
    input  logic [NFIELD-1:0] ld_en,
    input  logic [7:0]        ld_data,
    output rtc_fields_t       now
);
    rtc_fields_t nxt;

    // Next calendar value after one second.
    always_comb begin
        nxt = now;
        if (now[F_SEC] == 8'h59) begin
            nxt[F_SEC] = 8'h00;
            if (now[F_MIN] == 8'h59) begin
                nxt[F_MIN] = 8'h00;
                if (now[F_HOUR] == 8'h23) begin
                    nxt[F_HOUR] = 8'h00;
                    nxt[F_WDAY] = (now[F_WDAY] >= 8'h06) ? 8'h00 : now[F_WDAY] + 8'h01;
                    if (now[F_DAY] == bcd_last_day(now[F_MON], now[F_YEAR])) begin
                        nxt[F_DAY] = 8'h01;
                        if (now[F_MON] == 8'h12) begin
                            nxt[F_MON]  = 8'h01;
                            nxt[F_YEAR] = (now[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(now[F_YEAR]);
                        end else begin
                            nxt[F_MON] = bcd_inc(now[F_MON]);
                        end
                    end else begin
                        nxt[F_DAY] = bcd_inc(now[F_DAY]);
                    end
                end else begin
                    nxt[F_HOUR] = bcd_inc(now[F_HOUR]);
                end
            end else begin
                nxt[F_MIN] = bcd_inc(now[F_MIN]);
            end
        end else begin
            nxt[F_SEC] = bcd_inc(now[F_SEC]);
        end
    end

    // One register per field: load has priority over stepping.
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n)        now[g] <= reset_fields()[g];
            else if (ld_en[g]) now[g] <= ld_data;
            else if (sec_step) now[g] <= nxt[g];
        end
    end
endmodule

// File: rtl/rtc_alarm.sv
// Module rtc_alarm
// Alarm compare and sticky flag. The compare is sampled one clock after a
// seconds step, when the live fields have settled. Assumes clr is a
// single-cycle write-one-to-clear strobe; a set in the same clock wins.
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_step,
    input  rtc_fields_t now,
    input  rtc_alarm_t  alm,
    input  logic        clr,
    output logic        flag
);
    logic step_q;
    logic hit;

    // Remember that the live fields were just updated.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= 1'b0;
        else        step_q <= sec_step;
    end

    assign hit = step_q && (now[NALARM-1:0] == alm);

    // Sticky flag: set on a hit, else cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/rtc_regs.sv
// Module rtc_regs
// Register file: control, interrupt enable, compensation, alarm fields and
// the shadow bank. Decodes time loads (only while halted), the snapshot
// rising edge and the alarm clear, and muxes read data.
// Assumes a single write port and combinational reads.
module rtc_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  rtc_fields_t       now,
    input  logic              alm_flag,
    output logic              run,
    output logic              comp_en,
    output logic              irq_en,
    output logic [15:0]       comp_val,
    output rtc_alarm_t        alm,
    output logic [NFIELD-1:0] ld_en,
    output logic              snap_cap,
    output logic              alm_clr,
    output logic              running,
    output rtc_fields_t       shadow
);
    logic [2:0] ctrl_q;
    logic       wr_ctrl;
    logic       wr_stat;

    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    assign wr_stat  = reg_wr && (reg_addr == ADDR_W'(A_STAT));
    assign run      = ctrl_q[C_RUN];
    assign comp_en  = ctrl_q[C_COMP];
    assign snap_cap = wr_ctrl && reg_wdata[C_SNAP] && !ctrl_q[C_SNAP];
    assign alm_clr  = wr_stat && reg_wdata[1];

    // Time loads are accepted only while the clock is halted.
    always_comb begin
        for (int i = 0; i < NFIELD; i++)
            ld_en[i] = reg_wr && !run && (reg_addr == ADDR_W'(A_TIME0 + i));
    end

    // Control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= reg_wdata[2:0];
    end

    // Running status lags the run bit by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= run;
    end

    // Interrupt enable and compensation bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= 1'b0;
            comp_val <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_IEN))  irq_en         <= reg_wdata[0];
            if (reg_addr == ADDR_W'(A_CMPL)) comp_val[7:0]  <= reg_wdata;
            if (reg_addr == ADDR_W'(A_CMPH)) comp_val[15:8] <= reg_wdata;
        end
    end

    // One byte register per alarm field.
    for (genvar g = 0; g < NALARM; g++) begin : g_alm
        always_ff @(posedge clk) begin
            if (!rst_n)
                alm[g] <= '0;
            else if (reg_wr && (reg_addr == ADDR_W'(A_ALM0 + g)))
                alm[g] <= reg_wdata;
        end
    end

    // Shadow bank captures all live fields on a snapshot rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        shadow <= reset_fields();
        else if (snap_cap) shadow <= now;
    end

    // Read data mux.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NFIELD; i++)
            if (reg_addr == ADDR_W'(A_TIME0 + i)) reg_rdata = shadow[i];
        for (int i = 0; i < NALARM; i++)
            if (reg_addr == ADDR_W'(A_ALM0 + i)) reg_rdata = alm[i];
        if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata = {5'b0, ctrl_q};
        if (reg_addr == ADDR_W'(A_STAT)) reg_rdata = {6'b0, alm_flag, running};
        if (reg_addr == ADDR_W'(A_IEN))  reg_rdata = {7'b0, irq_en};
        if (reg_addr == ADDR_W'(A_CMPL)) reg_rdata = comp_val[7:0];
        if (reg_addr == ADDR_W'(A_CMPH)) reg_rdata = comp_val[15:8];
    end
endmodule

// File: rtl/bcd_rtc_core.sv
// Module bcd_rtc_core
// Top of the BCD calendar clock: register file, sub-second divider with
// hourly correction, calendar counters and alarm. Assumes tick_en is a
// one-cycle pulse per crystal period, synchronous to clk.
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int SUB_W  = 15,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              alarm_irq
);
    rtc_fields_t       now;
    rtc_fields_t       shadow;
    rtc_alarm_t        alm;
    logic [NFIELD-1:0] ld_en;
    logic [15:0]       comp_val;
    logic              run, comp_en, irq_en, running;
    logic              snap_cap, alm_clr, alm_flag;
    logic              sec_step, comp_evt;

    // Hourly correction point: the step from second 00 while minute is 00.
    assign comp_evt  = comp_en && (now[F_MIN] == 8'h00) && (now[F_SEC] == 8'h00);
    assign alarm_irq = alm_flag & irq_en;

    rtc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .now(now),
        .alm_flag(alm_flag), .run(run), .comp_en(comp_en), .irq_en(irq_en),
        .comp_val(comp_val), .alm(alm), .ld_en(ld_en), .snap_cap(snap_cap),
        .alm_clr(alm_clr), .running(running), .shadow(shadow)
    );

    rtc_subsec #(.SUB_W(SUB_W)) u_subsec (
        .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en),
        .comp_evt(comp_evt), .comp_val(comp_val), .sec_step(sec_step)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .sec_step(sec_step), .ld_en(ld_en),
        .ld_data(reg_wdata), .now(now)
    );

    rtc_alarm u_alarm (
        .clk(clk), .rst_n(rst_n), .sec_step(sec_step), .now(now),
        .alm(alm), .clr(alm_clr), .flag(alm_flag)
    );
endmodule

// File: rtl/rtc_core_chk.sv
// Module rtc_core_chk
// Property checker for bcd_rtc_core, bound to every instance of it.
module rtc_core_chk
    import rtc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        run,
    input logic        running,
    input logic        sec_step,
    input logic        ld_any,
    input logic        snap_cap,
    input logic        alm_flag,
    input logic        alarm_irq,
    input rtc_fields_t now,
    input rtc_fields_t shadow
);
    a_r3_step_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sec_step |-> (tick_en && run));

    a_r4_halt_holds_time: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_any) |=> $stable(now));

    a_r4_running_follows: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> running);

    a_r4_stopped_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !running);

    a_r5_shadow_only_on_snap: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_cap |=> $stable(shadow));

    a_r9_flag_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> $past(sec_step, 2));

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> alm_flag);
endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
    .running(running), .sec_step(sec_step), .ld_any(|ld_en),
    .snap_cap(snap_cap), .alm_flag(alm_flag), .alarm_irq(alarm_irq),
    .now(now), .shadow(shadow)
);

// File: tb/bcd_rtc_core_tb.sv
// Bench for bcd_rtc_core with a 16-tick second (SUB_W = 4).
module bcd_rtc_core_tb;
    localparam int CLK_P  = 10;
    localparam int SUB_W  = 4;
    localparam int TPS    = 1 << SUB_W;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              alarm_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [7:0] tv [0:6];

    always #(CLK_P/2) clk = ~clk;

    bcd_rtc_core #(.SUB_W(SUB_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .alarm_irq(alarm_irq)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic get_time(input logic [7:0] ctrl);
        wr('h10, ctrl & 8'hFD);
        wr('h10, ctrl | 8'h02);
        for (int i = 0; i < 7; i++) rd(i, tv[i]);
    endtask

    task automatic load(input int s, input int m, input int h, input int d,
                        input int mo, input int y, input int w, input logic [7:0] ctrl);
        wr('h10, 8'h00);
        wr(0, bcd(s)); wr(1, bcd(m)); wr(2, bcd(h)); wr(3, bcd(d));
        wr(4, bcd(mo)); wr(5, bcd(y)); wr(6, bcd(w));
        wr('h10, ctrl);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 7; i++) begin
            rd(i, r);
            check("R1 reset time", r, (i == 3 || i == 4) ? 8'h01 : 8'h00);
        end
        rd('h10, r); check("R1 reset ctrl", r, 8'h00);
        rd('h11, r); check("R1 reset status", r, 8'h00);
        rd('h14, r); check("R1 reset comp", r, 8'h00);
        check("R1 reset irq", alarm_irq, 1'b0);
        rd('h1F, r); check("R2 unmapped", r, 8'h00);

        // R3: halted clock ignores ticks
        ticks(3 * TPS);
        get_time(8'h00);
        check("R3 halted", tv[0], 8'h00);

        // R2 R3 R4: load, run, step timing, status
        load(10, 20, 5, 7, 3, 21, 2, 8'h01);
        rd('h11, r); check("R4 running", r, 8'h01);
        ticks(TPS - 1);
        get_time(8'h01); check("R3 not yet", tv[0], 8'h10);
        ticks(1);
        get_time(8'h01); check("R3 stepped", tv[0], 8'h11);
        check("R2 order hour", tv[2], 8'h05); check("R2 order month", tv[4], 8'h03);
        wr(0, 8'h45);
        get_time(8'h01); check("R4 write ignored running", tv[0], 8'h11);
        ticks(TPS / 2);
        wr('h10, 8'h00);
        rd('h11, r); check("R4 stopped", r, 8'h00);
        wr('h10, 8'h01);
        ticks(TPS - 1);
        get_time(8'h01); check("R4 phase restart", tv[0], 8'h11);
        ticks(1);
        get_time(8'h01); check("R4 full second", tv[0], 8'h12);

        // R6: seconds/minutes/hours cascade over 75 s
        load(50, 58, 0, 1, 1, 0, 0, 8'h01);
        ticks(75 * TPS);
        get_time(8'h01);
        check("R6 sec", tv[0], 8'h05); check("R6 min", tv[1], 8'h00);
        check("R6 hour", tv[2], 8'h01);

        // R6: month-end sweep over several years
        for (int yi = 0; yi < 4; yi++) begin
            int yr;
            yr = (yi == 0) ? 0 : (yi == 1) ? 23 : (yi == 2) ? 24 : 99;
            for (int mo = 1; mo <= 12; mo++) begin
                int w;
                w = mo % 7;
                load(59, 59, 23, dim(mo, yr), mo, yr, w, 8'h01);
                ticks(TPS);
                get_time(8'h01);
                check("R6 day wrap", tv[3], 8'h01);
                check("R6 month", tv[4], bcd(mo == 12 ? 1 : mo + 1));
                check("R6 year", tv[5], bcd(mo == 12 ? (yr + 1) % 100 : yr));
                check("R6 wday", tv[6], bcd((w + 1) % 7));
                check("R6 hms", {tv[2], tv[0]}, 16'h0000);
                load(59, 59, 23, dim(mo, yr) - 1, mo, yr, w, 8'h01);
                ticks(TPS);
                get_time(8'h01);
                check("R6 no early wrap", {tv[4], tv[3]}, {bcd(mo), bcd(dim(mo, yr))});
            end
        end

        // R7 R8 R11: hourly correction
        wr('h13, 8'h05); wr('h14, 8'h00);
        rd('h13, r); check("R11 comp low", r, 8'h05);
        rd('h14, r); check("R11 comp high", r, 8'h00);
        load(0, 0, 0, 1, 1, 0, 0, 8'h05);
        ticks(TPS); ticks(TPS - 5 - 1);
        get_time(8'h05); check("R7 +5 before", tv[0], 8'h01);
        ticks(1);
        get_time(8'h05); check("R7 +5 short second", tv[0], 8'h02);
        ticks(TPS - 1);
        get_time(8'h05); check("R8 later second", tv[0], 8'h02);
        ticks(1);
        get_time(8'h05); check("R8 later second end", tv[0], 8'h03);

        wr('h13, 8'hFD); wr('h14, 8'hFF);
        rd('h14, r); check("R11 comp high neg", r, 8'hFF);
        load(0, 0, 0, 1, 1, 0, 0, 8'h05);
        ticks(TPS); ticks(TPS + 3 - 1);
        get_time(8'h05); check("R7 -3 before", tv[0], 8'h01);
        ticks(1);
        get_time(8'h05); check("R7 -3 long second", tv[0], 8'h02);

        wr('h13, 8'hFF); wr('h14, 8'h7F);
        load(0, 0, 0, 1, 1, 0, 0, 8'h05);
        ticks(TPS); ticks(1);
        get_time(8'h05); check("R7 saturate positive", tv[0], 8'h02);

        wr('h13, 8'h00); wr('h14, 8'h80);
        load(0, 0, 0, 1, 1, 0, 0, 8'h05);
        ticks(TPS); ticks(2 * TPS - 2);
        get_time(8'h05); check("R7 saturate negative before", tv[0], 8'h01);
        ticks(1);
        get_time(8'h05); check("R7 saturate negative", tv[0], 8'h02);

        wr('h13, 8'h05); wr('h14, 8'h00);
        load(0, 0, 0, 1, 1, 0, 0, 8'h01);
        ticks(TPS); ticks(TPS - 1);
        get_time(8'h01); check("R8 disabled", tv[0], 8'h01);
        load(0, 5, 0, 1, 1, 0, 0, 8'h05);
        ticks(TPS); ticks(TPS - 1);
        get_time(8'h05); check("R8 minute nonzero", tv[0], 8'h01);
        wr('h13, 8'h00);

        // R9 R10: alarm, W1C, interrupt gating
        wr('h08, 8'h02); wr('h09, 8'h30); wr('h0A, 8'h12);
        wr('h0B, 8'h15); wr('h0C, 8'h06); wr('h0D, 8'h24);
        wr('h12, 8'h01);
        load(0, 30, 12, 15, 6, 24, 6, 8'h01);
        ticks(TPS);
        rd('h11, r); check("R9 no match", r, 8'h01);
        ticks(TPS);
        rd('h11, r); check("R9 match sets flag", r, 8'h03);
        check("R10 irq high", alarm_irq, 1'b1);
        wr('h11, 8'h01);
        rd('h11, r); check("R9 write 0 keeps flag", r, 8'h03);
        wr('h11, 8'h02);
        rd('h11, r); check("R9 w1c clears", r, 8'h01);
        check("R10 irq low", alarm_irq, 1'b0);
        ticks(TPS);
        rd('h11, r); check("R9 no refire", r, 8'h01);

        wr('h12, 8'h00);
        load(0, 30, 12, 15, 6, 24, 6, 8'h01);
        ticks(2 * TPS);
        rd('h11, r); check("R9 flag masked case", r, 8'h03);
        check("R10 irq masked", alarm_irq, 1'b0);
        wr('h12, 8'h01);
        check("R10 irq unmasked", alarm_irq, 1'b1);
        wr('h11, 8'h02);

        // R9: set and clear in the same clock
        load(0, 30, 12, 15, 6, 24, 6, 8'h01);
        ticks(TPS); ticks(TPS - 1);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        reg_wr = 1'b1; reg_addr = ADDR_W'('h11); reg_wdata = 8'h02;
        @(negedge clk); reg_wr = 1'b0;
        rd('h11, r); check("R9 set beats clear", r, 8'h03);
        check("R10 irq on collision", alarm_irq, 1'b1);
        wr('h11, 8'h02);

        // R5: snapshot on the step edge, and no recapture while bit stays 1
        load(10, 0, 0, 1, 1, 0, 0, 8'h01);
        ticks(TPS - 1);
        @(negedge clk);
        tick_en = 1'b1;
        reg_wr = 1'b1; reg_addr = ADDR_W'('h10); reg_wdata = 8'h03;
        @(negedge clk);
        tick_en = 1'b0; reg_wr = 1'b0;
        rd(0, r); check("R5 pre-step capture", r, 8'h10);
        get_time(8'h01); check("R5 fresh capture", tv[0], 8'h11);
        ticks(TPS);
        wr('h10, 8'h03);
        rd(0, r); check("R5 no recapture", r, 8'h11);
        get_time(8'h01); check("R5 new capture", tv[0], 8'h12);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule